// File: doc/BRIEF.md
# Page Entry Access Checker

This block sits behind a page-table walker. For every completed walk it takes the final page entry, the virtual address, the kind of access (load, store or instruction fetch) and the privilege of the requester. From these it decides whether the access is legal and which read, write and execute rights the mapping may be cached with. It also works out whether the entry's referenced and modified flags must be set and, if so, presents the updated entry and a write-back request to the memory side. Illegal accesses raise an instruction-fault or data-fault trap and are logged in a sticky fault status register and a fault address register.

Two bypass modes exist while translation is disabled. Addresses then pass through untranslated with full rights. When boot mode is also on, instruction fetches are steered into a boot ROM window, with read and execute rights only. A no-fault mode lets user accesses that break the permission rules continue without a trap. All results appear on registered outputs in the cycle after the request.

Page entry layout used throughout: bits [1:0] entry type (not examined), bits [4:2] access field, bit 5 referenced, bit 6 modified, bit 7 not examined, bits [31:8] physical page number. Access kind encoding on `req_kind`: 0 load, 1 store, 2 fetch, 3 treated as a load.

Top module: `pte_access_check`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero after that edge, including the fault status and fault address registers.
- R2: The access index is {store, fetch, supervisor} (bit 2 set for a store, bit 1 for a fetch, bit 0 when `req_user` is low). A user access to an entry whose access field is 6 or 7 yields fault code 12 (privilege). Otherwise the access yields code 8 (protection) when the privilege-adjusted rights lack read for a load, write for a store or execute for a fetch, and code 0 when they do not. A nonzero code with translation on and no suppression raises a trap. The response is valid in the cycle after `req_valid`.
- R3: Base rights by access field, as {r,w,x}: 0 r, 1 rw, 2 rx, 3 rwx, 4 x, 5 rw, 6 rx, 7 rwx. For a user requester, field 5 grants r only and fields 6 and 7 grant nothing. A trapping access reports no rights.
- R4: On a permitted translated access, write permission is reported only when bit 6 of the entry after update is set.
- R5: On a translated access that does not trap, bit 5 is set and, for a store, bit 6 is set. `wb_req` is raised exactly when this changes the entry. `wb_entry` carries the updated entry, or the unchanged input entry when no update applies.
- R6: With `nofault_en` high, a faulting user access raises no trap, reports full rights rwx, still updates the entry as in R5, and is still logged as in R7. A faulting supervisor access traps as usual.
- R7: On every translated access with a nonzero fault code, the fault status register is first set to 1 when it held any nonzero value. Then the value (access index << 5) | fault code | 2 is ORed in. The fault address register takes the virtual address with bits [11:0] cleared.
- R8: A `fsr_rd` pulse clears the fault status register at that edge. If a fault is logged at the same edge, it is recorded into the cleared register, so the overwrite bit 0 stays clear.
- R9: A trap drives `trap_inst` for a fetch and `trap_data` for any other kind, never both.
- R10: With `xlate_en` low, no fault is raised or logged, no write-back is requested, and the physical address is the virtual address, zero-extended, with rwx rights (except R11).
- R11: With `xlate_en` low and `boot_en` high, a fetch gets physical address `prom_base` ORed with VA[18:0] and rights r and x only. Loads and stores keep R10 behaviour.
- R12: On a translated access that does not trap, the physical address is the page number in bits [31:8] shifted left by 12. On a trap it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk result present this cycle |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Requester is in user mode |
| req_va | input | VA_W (32) | Virtual address |
| req_entry | input | ENT_W (32) | Final page entry from the walk |
| xlate_en | input | 1 | Translation enabled |
| nofault_en | input | 1 | No-fault mode for user accesses |
| boot_en | input | 1 | Boot mode for fetches while translation is off |
| prom_base | input | PA_W (36) | Boot ROM window base |
| fsr_rd | input | 1 | Fault status read strobe, clears it |
| resp_valid | output | 1 | Result valid |
| resp_pa | output | PA_W (36) | Physical address |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |
| wb_req | output | 1 | Entry write-back request |
| wb_entry | output | ENT_W (32) | Entry to write back |
| trap_inst | output | 1 | Instruction-fault trap |
| trap_data | output | 1 | Data-fault trap |
| fsr | output | FSR_W (32) | Fault status register |
| far | output | VA_W (32) | Fault address register |

## Verification
The embedded assertions check, on every cycle, the properties that hold for any input: the two trap outputs are exclusive, a trap never comes with a write-back or with rights, a write-back always carries the referenced bit, write permission on a normal access implies a modified entry, and the fault status register follows its logging, clearing and overwrite rules. The actual lookup values (which field and access index give code 8 or 12), the exact rights per privilege, the boot and pass-through addresses, no-fault suppression and the read-versus-fault ordering can only be shown by the bench scenarios, which compare every response against a table-driven model.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    // Entry field positions decoded by the walker and memory side
    localparam int FLD_LSB = 2;
    localparam int FLD_W   = 3;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

    // Fault codes
    localparam logic [3:0] FC_NONE = 4'd0;
    localparam logic [3:0] FC_PROT = 4'd8;
    localparam logic [3:0] FC_PRIV = 4'd12;

    // Fault status layout
    localparam int FS_IDX_SH = 5;
    localparam int FS_VALID  = 1;
    localparam int FS_OVW    = 0;

    localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};
    localparam perm_t PERM_ALL  = '{r: 1'b1, w: 1'b1, x: 1'b1};
    localparam perm_t PERM_RX   = '{r: 1'b1, w: 1'b0, x: 1'b1};

    function automatic logic [2:0] acc_index(input acc_kind_e k, input logic user);
        return {k == ACC_STORE, k == ACC_FETCH, ~user};
    endfunction

    function automatic perm_t base_perm(input logic [FLD_W-1:0] f);
        perm_t p;
        case (f)
            3'd0:    p = '{r: 1'b1, w: 1'b0, x: 1'b0};
            3'd1:    p = '{r: 1'b1, w: 1'b1, x: 1'b0};
            3'd2:    p = '{r: 1'b1, w: 1'b0, x: 1'b1};
            3'd3:    p = '{r: 1'b1, w: 1'b1, x: 1'b1};
            3'd4:    p = '{r: 1'b0, w: 1'b0, x: 1'b1};
            3'd5:    p = '{r: 1'b1, w: 1'b1, x: 1'b0};
            3'd6:    p = '{r: 1'b1, w: 1'b0, x: 1'b1};
            default: p = '{r: 1'b1, w: 1'b1, x: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pte_perm_decode.sv
module pte_perm_decode
    import pte_chk_pkg::*;
(
    input  logic [2:0]       idx,
    input  logic [FLD_W-1:0] field,
    output logic [3:0]       code,
    output perm_t            grant
);
    logic  user;
    logic  need_r, need_w, need_x;
    perm_t sup;

    assign user   = ~idx[0];
    assign need_w = idx[2];
    assign need_x = idx[1];
    assign need_r = ~idx[2] & ~idx[1];

    always_comb begin
        sup   = base_perm(field);
        grant = sup;
        if (user && field >= 3'd5) begin
            grant = (field == 3'd5) ? '{r: 1'b1, w: 1'b0, x: 1'b0} : PERM_NONE;
        end
    end

    always_comb begin
        if (user && field[2:1] == 2'b11) begin
            code = FC_PRIV;
        end else if ((need_r && !grant.r) || (need_w && !grant.w) || (need_x && !grant.x)) begin
            code = FC_PROT;
        end else begin
            code = FC_NONE;
        end
    end
endmodule

// File: rtl/pte_ref_update.sv
module pte_ref_update
    import pte_chk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry_in,
    input  logic             enable,
    input  logic             is_store,
    output logic [ENT_W-1:0] entry_out,
    output logic             changed
);
    always_comb begin
        entry_out = entry_in;
        if (enable) begin
            entry_out[REF_BIT] = 1'b1;
            if (is_store) begin
                entry_out[MOD_BIT] = 1'b1;
            end
        end
    end

    assign changed = (entry_out != entry_in);
endmodule

// File: rtl/pte_fault_regs.sv
module pte_fault_regs
    import pte_chk_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int FSR_W   = 32,
    parameter int PAGE_SH = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    log_en,
    input  logic [2:0]              idx,
    input  logic [3:0]              code,
    input  logic [VA_W-PAGE_SH-1:0] va_page,
    input  logic                    rd_clr,
    output logic [FSR_W-1:0]        fsr,
    output logic [VA_W-1:0]         far
);
    logic [FSR_W-1:0] fsr_q, base, fsr_d;
    logic [VA_W-1:0]  far_q;

    always_comb begin
        base  = rd_clr ? '0 : fsr_q;
        fsr_d = base;
        if (log_en) begin
            fsr_d = (base != '0) ? FSR_W'(1) : '0;
            fsr_d = fsr_d | (FSR_W'(idx) << FS_IDX_SH) | FSR_W'(code) | (FSR_W'(1) << FS_VALID);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_d;
            if (log_en) begin
                far_q <= {va_page, {PAGE_SH{1'b0}}};
            end
        end
    end

    assign fsr = fsr_q;
    assign far = far_q;

    // R7
    logged_valid_chk: assert property (@(posedge clk) disable iff (rst)
        log_en |=> fsr_q[FS_VALID]);

    // R7
    overwrite_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (log_en && !rd_clr && fsr_q != '0) |=> fsr_q[FS_OVW]);

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !log_en) |=> fsr_q == '0);

    // R8
    read_then_log_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && log_en) |=> !fsr_q[FS_OVW]);
endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
    import pte_chk_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 36,
    parameter int ENT_W   = 32,
    parameter int FSR_W   = 32,
    parameter int PAGE_SH = 12,
    parameter int PPN_LSB = 8,
    parameter int BOOT_W  = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [VA_W-1:0]  req_va,
    input  logic [ENT_W-1:0] req_entry,
    input  logic             xlate_en,
    input  logic             nofault_en,
    input  logic             boot_en,
    input  logic [PA_W-1:0]  prom_base,
    input  logic             fsr_rd,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_pa,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x,
    output logic             wb_req,
    output logic [ENT_W-1:0] wb_entry,
    output logic             trap_inst,
    output logic             trap_data,
    output logic [FSR_W-1:0] fsr,
    output logic [VA_W-1:0]  far
);
    localparam int PPN_W = ENT_W - PPN_LSB;

    acc_kind_e        kind;
    logic [2:0]       idx;
    logic [3:0]       code;
    perm_t            grant, eff;
    logic             fault_hit, suppress, trap, proceed, is_fetch, boot_fetch;
    logic [ENT_W-1:0] upd_entry;
    logic             upd_changed;
    logic [PA_W-1:0]  pa;

    assign kind       = acc_kind_e'(req_kind);
    assign idx        = acc_index(kind, req_user);
    assign is_fetch   = (kind == ACC_FETCH);
    assign boot_fetch = boot_en && is_fetch;

    pte_perm_decode u_dec (
        .idx   (idx),
        .field (req_entry[FLD_LSB +: FLD_W]),
        .code  (code),
        .grant (grant)
    );

    assign fault_hit = xlate_en && (code != FC_NONE);
    assign suppress  = nofault_en && req_user;
    assign trap      = fault_hit && !suppress;
    assign proceed   = xlate_en && !trap;

    pte_ref_update #(.ENT_W(ENT_W)) u_upd (
        .entry_in  (req_entry),
        .enable    (proceed),
        .is_store  (kind == ACC_STORE),
        .entry_out (upd_entry),
        .changed   (upd_changed)
    );

    always_comb begin
        if (!xlate_en) begin
            eff = boot_fetch ? PERM_RX : PERM_ALL;
        end else if (trap) begin
            eff = PERM_NONE;
        end else if (fault_hit) begin
            eff = PERM_ALL;
        end else begin
            eff   = grant;
            eff.w = grant.w && upd_entry[MOD_BIT];
        end
    end

    always_comb begin
        if (!xlate_en) begin
            pa = boot_fetch ? (prom_base | PA_W'(req_va[BOOT_W-1:0])) : PA_W'(req_va);
        end else if (trap) begin
            pa = '0;
        end else begin
            pa = PA_W'(req_entry[ENT_W-1 -: PPN_W]) << PAGE_SH;
        end
    end

    pte_fault_regs #(.VA_W(VA_W), .FSR_W(FSR_W), .PAGE_SH(PAGE_SH)) u_fregs (
        .clk     (clk),
        .rst     (rst),
        .log_en  (req_valid && fault_hit),
        .idx     (idx),
        .code    (code),
        .va_page (req_va[VA_W-1:PAGE_SH]),
        .rd_clr  (fsr_rd),
        .fsr     (fsr),
        .far     (far)
    );

    logic normal_q;

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            perm_r     <= 1'b0;
            perm_w     <= 1'b0;
            perm_x     <= 1'b0;
            wb_req     <= 1'b0;
            wb_entry   <= '0;
            trap_inst  <= 1'b0;
            trap_data  <= 1'b0;
            normal_q   <= 1'b0;
        end else begin
            resp_valid <= 1'b1;
            resp_pa    <= pa;
            perm_r     <= eff.r;
            perm_w     <= eff.w;
            perm_x     <= eff.x;
            wb_req     <= upd_changed;
            wb_entry   <= upd_entry;
            trap_inst  <= trap && is_fetch;
            trap_data  <= trap && !is_fetch;
            normal_q   <= xlate_en && !fault_hit;
        end
    end

    // R9
    trap_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(trap_inst && trap_data));

    // R5
    trap_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_inst || trap_data) |-> (!wb_req && !perm_r && !perm_w && !perm_x));

    // R5
    wb_has_ref_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> (resp_valid && wb_entry[REF_BIT]));

    // R4
    write_needs_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (normal_q && perm_w) |-> wb_entry[MOD_BIT]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!wb_req && !trap_inst && !trap_data));
endmodule

// File: tb/sim_pte_access_check.sv
module sim_pte_access_check;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic [31:0] req_entry = '0;
    logic        xlate_en = 1'b1;
    logic        nofault_en = 1'b0;
    logic        boot_en = 1'b0;
    logic [35:0] prom_base = 36'hF_F000_0000;
    logic        fsr_rd = 1'b0;
    logic        resp_valid, perm_r, perm_w, perm_x, wb_req, trap_inst, trap_data;
    logic [35:0] resp_pa;
    logic [31:0] wb_entry, fsr, far;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_fsr = '0;
    logic [31:0] m_far = '0;

    // fault code per access index, nibble n = access field n
    logic [31:0] code_tab [8] = '{32'hCC080000, 32'h00080000, 32'hCC800088, 32'h00800088,
                                  32'hCC880808, 32'h08080808, 32'hCC880888, 32'h08880888};
    // rights {r,w,x} per access field
    int sup_p [8] = '{4, 6, 5, 7, 1, 6, 5, 7};
    int usr_p [8] = '{4, 6, 5, 7, 1, 4, 0, 0};

    pte_access_check u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_user(req_user), .req_va(req_va), .req_entry(req_entry),
        .xlate_en(xlate_en), .nofault_en(nofault_en), .boot_en(boot_en),
        .prom_base(prom_base), .fsr_rd(fsr_rd), .resp_valid(resp_valid),
        .resp_pa(resp_pa), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
        .wb_req(wb_req), .wb_entry(wb_entry), .trap_inst(trap_inst),
        .trap_data(trap_data), .fsr(fsr), .far(far)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic logic [31:0] mk(input logic [23:0] ppn, input bit m, input bit r, input int acc);
        logic [2:0] a = 3'(acc);
        return {ppn, 1'b0, m, r, a, 2'b10};
    endfunction

    task automatic apply(input logic [1:0] k, input bit usr, input logic [31:0] va,
                         input logic [31:0] ent, input bit rd, input string tag);
        logic [2:0]  idx;
        logic [3:0]  code;
        bit          logit, supp, trp, go, fetch;
        logic [31:0] nent;
        logic [2:0]  perm;
        logic [35:0] pa;
        int          acc;
        acc   = int'(ent[4:2]);
        fetch = (k == 2'd2);
        idx   = {k == 2'd1, fetch, !usr};
        code  = 4'((code_tab[idx] >> (4 * acc)) & 32'hF);
        logit = xlate_en && code != 0;
        supp  = nofault_en && usr;
        trp   = logit && !supp;
        go    = xlate_en && !trp;
        nent  = ent;
        if (go) begin
            nent[5] = 1'b1;
            if (k == 2'd1) nent[6] = 1'b1;
        end
        if (!xlate_en) begin
            perm = (boot_en && fetch) ? 3'b101 : 3'b111;
            pa   = (boot_en && fetch) ? (prom_base | {17'd0, va[18:0]}) : {4'd0, va};
        end else if (trp) begin
            perm = 3'b000;
            pa   = '0;
        end else begin
            perm = logit ? 3'b111 : 3'(usr ? usr_p[acc] : sup_p[acc]);
            if (!logit && !nent[6]) perm[1] = 1'b0;
            pa = {ent[31:8], 12'h000};
        end
        if (rd) m_fsr = '0;
        if (logit) begin
            m_fsr = (m_fsr != 0) ? 32'd1 : 32'd0;
            m_fsr = m_fsr | (32'(idx) << 5) | 32'(code) | 32'd2;
            m_far = va & 32'hFFFF_F000;
        end
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_user = usr; req_va = va; req_entry = ent; fsr_rd = rd;
        @(posedge clk); #1;
        req_valid = 1'b0; fsr_rd = 1'b0;
        chk(tag, "valid", 64'(resp_valid), 64'd1);
        chk(tag, "perm", 64'({perm_r, perm_w, perm_x}), 64'(perm));
        chk(tag, "trap", 64'({trap_inst, trap_data}), 64'({trp && fetch, trp && !fetch}));
        chk(tag, "pa", 64'(resp_pa), 64'(pa));
        chk(tag, "wb", 64'({wb_req, wb_entry}), 64'({go && (nent != ent), nent}));
        chk(tag, "fsr", 64'(fsr), 64'(m_fsr));
        chk(tag, "far", 64'(far), 64'(m_far));
    endtask

    task automatic read_fsr(input string tag);
        m_fsr = '0;
        @(negedge clk); fsr_rd = 1'b1;
        @(posedge clk); #1; fsr_rd = 1'b0;
        chk(tag, "fsr after read", 64'(fsr), 64'd0);
        chk(tag, "idle valid", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "outputs", 64'({resp_valid, perm_r, perm_w, perm_x, wb_req, trap_inst, trap_data}), 64'd0);
        chk("R1", "fsr/far", {fsr, far}, 64'd0);
        @(negedge clk); rst = 1'b0;

        // R2 full lookup sweep, R9 trap choice within it
        for (int k = 0; k < 3; k++)
            for (int u = 0; u < 2; u++)
                for (int a = 0; a < 8; a++)
                    apply(2'(k), bit'(u), 32'h0040_0000 + 32'(a * 4096 + 12), mk(24'h100 + 24'(a), 1, 1, a), 0, "R2");
        read_fsr("R8");

        // R3 rights for fields 5..7 by privilege
        for (int a = 5; a < 8; a++) begin
            apply(2'd0, 0, 32'h1000, mk(24'h222, 1, 1, a), 0, "R3");
            apply(2'd0, 1, 32'h1000, mk(24'h222, 1, 1, a), 0, "R3");
        end
        read_fsr("R8");

        // R4 write right waits for modified bit
        apply(2'd0, 0, 32'h2000, mk(24'h333, 0, 1, 1), 0, "R4");
        apply(2'd1, 0, 32'h2000, mk(24'h333, 0, 1, 1), 0, "R4");

        // R5 referenced / modified update
        apply(2'd0, 1, 32'h3000, mk(24'h444, 0, 0, 3), 0, "R5");
        apply(2'd1, 1, 32'h3000, mk(24'h444, 0, 1, 3), 0, "R5");
        apply(2'd2, 1, 32'h3000, mk(24'h444, 1, 1, 3), 0, "R5");
        apply(2'd1, 0, 32'h3000, mk(24'h444, 0, 0, 0), 0, "R5");

        // R6 no-fault mode
        nofault_en = 1'b1;
        apply(2'd1, 1, 32'h5000_5123, mk(24'h555, 0, 0, 0), 0, "R6");
        apply(2'd2, 1, 32'h5000_6000, mk(24'h555, 0, 1, 7), 0, "R6");
        apply(2'd1, 0, 32'h5000_7000, mk(24'h555, 0, 1, 0), 0, "R6");
        nofault_en = 1'b0;

        // R7 overwrite marking over consecutive faults
        read_fsr("R7");
        apply(2'd0, 1, 32'h6789_ABCD, mk(24'h666, 1, 1, 4), 0, "R7");
        apply(2'd2, 1, 32'h1234_5678, mk(24'h666, 1, 1, 6), 0, "R7");

        // R8 read and fault at the same edge
        apply(2'd1, 1, 32'h0ABC_0FFF, mk(24'h777, 1, 1, 0), 1, "R8");
        read_fsr("R8");

        // R9 fetch vs data trap
        apply(2'd2, 0, 32'h8000, mk(24'h888, 1, 1, 1), 0, "R9");
        apply(2'd0, 0, 32'h8000, mk(24'h888, 1, 1, 4), 0, "R9");

        // R10 translation off
        xlate_en = 1'b0;
        apply(2'd1, 1, 32'hDEAD_BEEF, mk(24'h999, 0, 0, 6), 0, "R10");
        apply(2'd2, 1, 32'hCAFE_F00D, mk(24'h999, 0, 0, 6), 0, "R10");

        // R11 boot mode
        boot_en = 1'b1;
        apply(2'd2, 0, 32'hFFFF_FFFF, mk(24'hAAA, 0, 0, 0), 0, "R11");
        apply(2'd2, 1, 32'h0004_1234, mk(24'hAAA, 0, 0, 0), 0, "R11");
        apply(2'd0, 0, 32'h0004_1234, mk(24'hAAA, 0, 0, 0), 0, "R11");
        boot_en = 1'b0; xlate_en = 1'b1;

        // R12 translated physical address
        apply(2'd0, 0, 32'h7777_7777, mk(24'hFFFFFF, 1, 1, 3), 0, "R12");
        apply(2'd2, 0, 32'h7777_7777, mk(24'h000001, 1, 1, 2), 0, "R12");

        // R1 idle response after traffic
        @(negedge clk); @(posedge clk); #1;
        chk("R1", "idle valid", 64'(resp_valid), 64'd0);

        finish_run();
    end
endmodule